// File: doc/BRIEF.md
# Periodic Compare Timer

This block is a counter with a small set of compare channels and a register bus. Slot 0 is a compare register that also sets the period. Slots 1 and 2 are plain compare channels. Each enabled tick moves the counter on, in one of three modes:

- **Halt**: the counter stays where it is.
- **Up**: the counter counts from zero to the slot 0 value and then returns to zero.
- **Free**: the counter runs over its full range and rolls over.

Every channel raises a flag on the tick that brings the counter onto its value. A rollover flag marks each return to zero.

Two interrupt lines are built from the flags:

- **`irq0`** carries the slot 0 flag alone. That flag clears when the interrupt is acknowledged.
- **`irq_shared`** gathers the other channel flags and the rollover flag. These flags stay set until software rewrites the flag register.

Each flag reaches its line only through its own enable bit.

A typical use is to program slot 0 for a fixed period. A secondary channel then places an event at a fixed offset inside each period.

Top module: `tcc_timer`

## Requirements
- R1: In up mode the counter steps 0,1,…,C0 and then back to 0, where C0 is the slot 0 value, so a period lasts C0+1 ticks. The slot 0 flag (flag bit 0) sets on the tick that brings the counter to C0.
- R2: In free mode the counter goes from 65535 to 0. The rollover flag (flag bit 3) sets on that tick. Every channel fires once per lap at its own value, including values above C0.
- R3: A channel flag (bit k for slot k) sets on the tick that brings the counter to that slot's value. In up mode, a slot whose value exceeds C0 never sets its flag.
- R4: In up mode the rollover flag sets on the tick after the slot 0 flag sets, when the counter goes from C0 to 0.
- R5: Halt mode holds the count. Writing a new mode leaves the count unchanged. Writing 1 to control bit 2 zeroes the count in that cycle.
- R6: The counter changes only in cycles where `tick_en` is 1.
- R7: `irq0` equals flag bit 0 AND enable bit 0. A high `irq0_ack` clears flag bit 0 and no other flag.
- R8: `irq_shared` is the OR, over flag bits 1 to 3, of each flag ANDed with its enable. These flags stay set until the flag register is written. Flags can be read and written whatever their enables are.
- R9: When a hardware event sets a flag in the same cycle as a software write or acknowledge that would clear it, the flag ends up set.
- R10: The register map is as follows.
  - Address 0 is control. Bits 1:0 hold the mode: 00 halt, 01 up, 10 free, and 11 reads back as 00 and halts. Bit 2 is the clear bit and reads as 0. Bits 7:4 are the enables for flags 0 to 3.
  - Address 1 holds the flags in bits 3:0.
  - Address 2 is the count. It is read-only.
  - Addresses 3 to 5 hold the compare values of slots 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-enable strobe |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational on `bus_addr`) |
| irq0_ack | input | 1 | Acknowledge of the slot 0 interrupt |
| irq0 | output | 1 | Slot 0 interrupt request |
| irq_shared | output | 1 | Combined request from slots 1, 2 and rollover |

## Verification
Two things can happen to a flag in the same clock cycle. A compare match can set it, and a software write or an acknowledge can clear it.

The bench provokes this in two ways:
- It writes zero to the flag register in the very cycle whose tick brings the counter onto slot 1's value.
- It raises `irq0_ack` on the tick that reaches the slot 0 value.

In both cases the flag must read back as set afterwards. Flags with no event in that cycle must follow the software action.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [1:0] {
        TM_HALT = 2'b00,
        TM_UP   = 2'b01,
        TM_FREE = 2'b10
    } tmode_e;

    localparam int unsigned RA_CTRL      = 0;
    localparam int unsigned RA_FLAG      = 1;
    localparam int unsigned RA_COUNT     = 2;
    localparam int unsigned RA_CMP0      = 3;
    localparam int unsigned CTRL_CLR_BIT = 2;
    localparam int unsigned CTRL_IE_LSB  = 4;

    function automatic tmode_e decode_mode(input logic [1:0] f);
        case (f)
            2'b01:   return TM_UP;
            2'b10:   return TM_FREE;
            default: return TM_HALT;
        endcase
    endfunction

endpackage

// File: rtl/tcc_counter.sv
module tcc_counter
    import tcc_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  tmode_e           mode,
    input  logic             clr,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             adv,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic at_top;

    always_comb begin
        at_top  = (mode == TM_UP) ? (cnt >= top) : (cnt == CNT_MAX);
        adv     = tick && (mode != TM_HALT) && !clr;
        wrap    = adv && at_top;
        cnt_nxt = at_top ? '0 : cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (adv)
            cnt <= cnt_nxt;
    end

    AST_UP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (adv && mode == TM_UP && cnt <= top) |=> (cnt <= $past(top))); // R1
    AST_FREE_ROLL: assert property (@(posedge clk) disable iff (rst)
        (adv && mode == TM_FREE && cnt == CNT_MAX) |=> (cnt == '0)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(cnt)); // R6
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0)); // R5

endmodule

// File: rtl/tcc_match.sv
module tcc_match #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned N_CH  = 3
) (
    input  logic                       adv,
    input  logic [CNT_W-1:0]           cnt_nxt,
    input  logic [N_CH-1:0][CNT_W-1:0] cmp_vec,
    output logic [N_CH-1:0]            hit
);
    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        assign hit[k] = adv && (cnt_nxt == cmp_vec[k]);
    end
endmodule

// File: rtl/tcc_timer.sv
module tcc_timer
    import tcc_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned N_CH   = 3,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              irq0_ack,
    output logic              irq0,
    output logic              irq_shared
);
    localparam int unsigned NF       = N_CH + 1;
    localparam int unsigned WRAP_IDX = N_CH;

    typedef struct packed {
        tmode_e          mode;
        logic [NF-1:0]   ie;
    } ctrl_t;

    ctrl_t                      ctrl_q;
    logic [N_CH-1:0][CNT_W-1:0] cmp_q;
    logic [NF-1:0]              fl_q, fl_d, set_vec;
    logic [CNT_W-1:0]           cnt, cnt_nxt;
    logic                       adv, wrap, clr_pulse, wr_ctrl, wr_flag;
    logic [N_CH-1:0]            hit;

    assign wr_ctrl   = bus_we && (bus_addr == ADDR_W'(RA_CTRL));
    assign wr_flag   = bus_we && (bus_addr == ADDR_W'(RA_FLAG));
    assign clr_pulse = wr_ctrl && bus_wdata[CTRL_CLR_BIT];

    tcc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick_en), .mode(ctrl_q.mode),
        .clr(clr_pulse), .top(cmp_q[0]), .cnt(cnt), .cnt_nxt(cnt_nxt),
        .adv(adv), .wrap(wrap)
    );

    tcc_match #(.CNT_W(CNT_W), .N_CH(N_CH)) u_match (
        .adv(adv), .cnt_nxt(cnt_nxt), .cmp_vec(cmp_q), .hit(hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.mode <= TM_HALT;
            ctrl_q.ie   <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.mode <= decode_mode(bus_wdata[1:0]);
            ctrl_q.ie   <= bus_wdata[CTRL_IE_LSB +: NF];
        end
    end

    for (genvar k = 0; k < N_CH; k++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst)
                cmp_q[k] <= '0;
            else if (bus_we && bus_addr == ADDR_W'(RA_CMP0 + k))
                cmp_q[k] <= bus_wdata;
        end
    end

    assign set_vec = {wrap, hit};

    always_comb begin
        fl_d = fl_q;
        if (wr_flag)
            fl_d = bus_wdata[NF-1:0];
        if (irq0_ack)
            fl_d[0] = 1'b0;
        fl_d = fl_d | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst)
            fl_q <= '0;
        else
            fl_q <= fl_d;
    end

    assign irq0       = fl_q[0] && ctrl_q.ie[0];
    assign irq_shared = |(fl_q[NF-1:1] & ctrl_q.ie[NF-1:1]);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(RA_CTRL)) begin
            bus_rdata[1:0]               = ctrl_q.mode;
            bus_rdata[CTRL_IE_LSB +: NF] = ctrl_q.ie;
        end else if (bus_addr == ADDR_W'(RA_FLAG)) begin
            bus_rdata[NF-1:0] = fl_q;
        end else if (bus_addr == ADDR_W'(RA_COUNT)) begin
            bus_rdata = cnt;
        end
        for (int k = 0; k < N_CH; k++)
            if (bus_addr == ADDR_W'(RA_CMP0 + k))
                bus_rdata = cmp_q[k];
    end

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (irq0_ack && !set_vec[0]) |=> !fl_q[0]); // R7
    AST_SHARED_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fl_q[1] && !wr_flag) |=> fl_q[1]); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_vec[1] |=> fl_q[1]); // R9
    AST_ABOVE_TOP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode == TM_UP && cnt <= cmp_q[0] && cmp_q[1] > cmp_q[0])
        |-> !set_vec[1]); // R3
    AST_UP_ROLL_LAG: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode == TM_UP && set_vec[WRAP_IDX]) |-> (cnt >= cmp_q[0])); // R4

endmodule

// File: tb/test_tcc_timer.sv
module test_tcc_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq0_ack = 1'b0;
    logic        irq0, irq_shared;

    int n_cmp = 0;
    int n_bad = 0;
    int n_cyc = 0;
    bit done  = 1'b0;

    localparam logic [2:0] A_CTRL = 3'd0, A_FLAG = 3'd1, A_CNT = 3'd2,
                           A_C0 = 3'd3, A_C1 = 3'd4, A_C2 = 3'd5;

    always #4 clk = ~clk;

    tcc_timer i_tcc_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq0_ack(irq0_ack), .irq0(irq0), .irq_shared(irq_shared)
    );

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 200000 && !done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got %0d cycles exp < 200000", n_cyc);
            report();
        end
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    // one clock: drive from a falling edge to the next one
    task automatic cyc(input logic we, input logic [2:0] a, input logic [15:0] d,
                       input logic tk, input logic ak);
        bus_we = we; bus_addr = a; bus_wdata = d; tick_en = tk; irq0_ack = ak;
        @(negedge clk);
        bus_we = 1'b0; tick_en = 1'b0; irq0_ack = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        cyc(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 16'h0, 1'b1, 1'b0);
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(A_CNT, v);  chk("R10 reset count", v, 16'h0);
        rd(A_FLAG, v); chk("R10 reset flags", v, 16'h0);
        rd(A_CTRL, v); chk("R10 reset ctrl", v, 16'h0);
        chk("R7 reset irqs", {14'h0, irq0, irq_shared}, 16'h0);
    endtask

    task automatic t_up_mode();
        logic [15:0] v;
        wr(A_C0, 16'd4); wr(A_C1, 16'd2); wr(A_C2, 16'd9); wr(A_FLAG, 16'h0);
        wr(A_CTRL, 16'h00F5);
        rd(A_CTRL, v); chk("R10 ctrl readback clr reads 0", v, 16'h00F1);
        rd(A_CNT, v);  chk("R5 clear zeroes count", v, 16'd0);
        ticks(2);
        rd(A_CNT, v);  chk("R1 count after 2 ticks", v, 16'd2);
        rd(A_FLAG, v); chk("R3 slot1 flag at its value", v, 16'h2);
        ticks(2);
        rd(A_CNT, v);  chk("R1 count at top", v, 16'd4);
        rd(A_FLAG, v); chk("R1 slot0 flag at top", v, 16'h3);
        chk("R7 irq0 and R8 shared raised", {14'h0, irq0, irq_shared}, 16'h3);
        wr(A_FLAG, 16'h0);
        chk("R8 irqs drop after flag write", {14'h0, irq0, irq_shared}, 16'h0);
        ticks(1);
        rd(A_CNT, v);  chk("R1 return to zero", v, 16'd0);
        rd(A_FLAG, v); chk("R4 rollover one tick after slot0", v, 16'h8);
        ticks(4);
        rd(A_FLAG, v); chk("R1 one period sets 0,1,rollover", v, 16'hB);
        wr(A_FLAG, 16'h0);
        ticks(20);
        rd(A_CNT, v);  chk("R1 period of C0+1 ticks", v, 16'd4);
        rd(A_FLAG, v); chk("R3 slot above C0 never fires", v, 16'hB);
    endtask

    task automatic t_gate_and_halt();
        logic [15:0] v;
        for (int i = 0; i < 10; i++) cyc(1'b0, 3'd0, 16'h0, 1'b0, 1'b0);
        rd(A_CNT, v); chk("R6 no tick no count", v, 16'd4);
        wr(A_CTRL, 16'h00F0);
        ticks(5);
        rd(A_CNT, v); chk("R5 halt holds", v, 16'd4);
        wr(A_CTRL, 16'h00F2);
        rd(A_CNT, v); chk("R5 mode write keeps count", v, 16'd4);
        ticks(3);
        rd(A_CNT, v); chk("R5 free resumes", v, 16'd7);
        wr(A_CTRL, 16'h00F7);
        rd(A_CTRL, v); chk("R10 mode 11 reads as halt", v, 16'h00F0);
        rd(A_CNT, v); chk("R5 clear bit", v, 16'd0);
        ticks(2);
        rd(A_CNT, v); chk("R10 mode 11 halts", v, 16'd0);
    endtask

    task automatic t_free_mode();
        logic [15:0] v;
        wr(A_FLAG, 16'h0); wr(A_C1, 16'd100);
        wr(A_CTRL, 16'h00F6);
        ticks(65535);
        rd(A_CNT, v);  chk("R2 reaches full count", v, 16'hFFFF);
        rd(A_FLAG, v); chk("R2 all slots fire in a lap, no rollover yet", v, 16'h7);
        ticks(1);
        rd(A_CNT, v);  chk("R2 rolls to zero", v, 16'd0);
        rd(A_FLAG, v); chk("R2 rollover flag", v, 16'hF);
    endtask

    task automatic t_irq_paths();
        logic [15:0] v;
        cyc(1'b0, 3'd0, 16'h0, 1'b0, 1'b1);
        rd(A_FLAG, v); chk("R7 ack clears only slot0", v, 16'hE);
        chk("R7 irq0 low, shared high", {14'h0, irq0, irq_shared}, 16'h1);
        wr(A_CTRL, 16'h0000);
        chk("R8 shared masked", {15'h0, irq_shared}, 16'h0);
        rd(A_FLAG, v); chk("R8 flags kept while masked", v, 16'hE);
        wr(A_FLAG, 16'h2);
        rd(A_FLAG, v); chk("R8 flag writable while masked", v, 16'h2);
        wr(A_CTRL, 16'h0020);
        chk("R8 shared from slot1 enable", {15'h0, irq_shared}, 16'h1);
        for (int i = 0; i < 5; i++) cyc(1'b0, 3'd0, 16'h0, 1'b0, 1'b0);
        rd(A_FLAG, v); chk("R8 flag sticky", v, 16'h2);
    endtask

    task automatic t_collisions();
        logic [15:0] v;
        wr(A_FLAG, 16'h0); wr(A_C0, 16'd4); wr(A_C1, 16'd2);
        wr(A_CTRL, 16'h00F5);
        ticks(1);
        cyc(1'b1, A_FLAG, 16'h0, 1'b1, 1'b0);
        rd(A_FLAG, v); chk("R9 match beats flag write", v, 16'h2);
        ticks(6);
        rd(A_CNT, v);  chk("R1 count before ack collision", v, 16'd3);
        cyc(1'b0, 3'd0, 16'h0, 1'b1, 1'b1);
        rd(A_FLAG, v); chk("R9 match beats ack", v[0], 16'h1);
        chk("R7 irq0 after collision", {15'h0, irq0}, 16'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_up_mode();
        t_gate_and_halt();
        t_free_mode();
        t_irq_paths();
        t_collisions();
        done = 1'b1;
        report();
    end

endmodule